// File: doc/BRIEF.md
# Banked Register File with Indirect Burst RAM Port

This block is the byte-wide register and memory front end of a real-time-clock style device. A host reaches it over a simple synchronous bus: an 8-bit offset, a one-cycle write strobe, a read strobe, and read data that follows the offset in the same cycle. The low part of the map holds four control registers and a 50-byte scratch RAM. Those locations do not depend on any mode.

The window at offsets 0x40 to 0x7F has two views. Bit 4 of control register A picks the view. In bank 0 the window is a 64-byte general-purpose RAM. In bank 1 it shows read-only identification bytes, two extended control registers and an indirect port into a larger extended RAM. That RAM is addressed through a 16-bit pointer held in two byte registers. When bit 5 of extended control register 0x4A is set, the pointer steps forward on every data-port access and wraps at the top of the RAM. Software can therefore stream a block with repeated accesses to a single offset.

Top module: `rtc_bank_regs`

## Requirements
- R1: After a synchronous active-low reset, control registers 0x0A to 0x0D, extended control registers 0x4A and 0x4B and the 16-bit extended RAM pointer all read 0x00, so bank 0 is selected.
- R2: When bit 4 of register 0x0A is 0, offsets 0x40 to 0x7F map to a 64-byte read/write RAM indexed by offset minus 0x40. Its contents survive a visit to bank 1.
- R3: Offsets 0x0E to 0x3F map to a 50-byte read/write RAM indexed by offset minus 0x0E, in either bank.
- R4: In bank 1, offset 0x40+i (i from 0 to 7) reads byte i of the ID_BYTES parameter, which is bits 8i+7 down to 8i. Writes to these offsets change nothing.
- R5: Register 0x0C stores bits 7:4 only, and its bits 3:0 always read 0. Register 0x0D stores bit 7 only, and its bits 6:0 always read 0.
- R6: In bank 1, offset 0x50 reads and writes the low byte of the extended RAM pointer and offset 0x51 the high byte. Offset 0x53 reads or writes the extended RAM byte at the pointer value modulo XRAM_BYTES.
- R7: With bit 5 of 0x4A set, every data-port access (a write, or a read with the read strobe high) moves the pointer to (pointer mod XRAM_BYTES + 1) mod XRAM_BYTES. With bit 5 clear, or with an access to 0x53 that raises no strobe, the pointer keeps its value.
- R8: A burst access made when the pointer modulo XRAM_BYTES equals XRAM_BYTES-1 leaves the pointer at 0x0000.
- R9: Unmapped offsets read 0x00 and ignore writes. These are 0x00 to 0x09, 0x80 to 0xFF, and in bank 1 the offsets 0x48, 0x49, 0x4C to 0x4F, 0x52 and 0x54 to 0x7F.
- R10: Registers 0x0A, 0x0B, 0x4A and 0x4B hold all eight written bits. Read data is combinational for the offset presented, and a write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | Read strobe; counts as a data-port access for burst stepping |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The in-line assertions check the following on every cycle:
- the pointer step under burst mode, including the wrap to zero;
- that the pointer holds with burst mode off;
- that a data-port write is read back at an unchanged pointer;
- that the window decode agrees with the bank bit;
- the read-as-zero bits of 0x0C;
- that unmapped offsets return zero.

The bench's scenarios cover everything that depends on stored history. That includes RAM contents surviving bank switches, identification bytes ignoring writes, and a full burst fill and read-back of the extended RAM. It also covers a pointer written to a value above the RAM size, which is then folded on the next access.

// File: rtl/rtc_bank_pkg.sv
// Shared offsets, control bit positions and decode regions for the banked
// register file. Assumes an 8-bit offset bus.
package rtc_bank_pkg;
    localparam logic [7:0] OFF_CTRL_A   = 8'h0A;
    localparam logic [7:0] OFF_CTRL_B   = 8'h0B;
    localparam logic [7:0] OFF_CTRL_C   = 8'h0C;
    localparam logic [7:0] OFF_CTRL_D   = 8'h0D;
    localparam logic [7:0] OFF_LO_FIRST = 8'h0E;
    localparam logic [7:0] OFF_LO_LAST  = 8'h3F;
    localparam logic [7:0] OFF_ID_LAST  = 8'h47;
    localparam logic [7:0] OFF_XCTL_A   = 8'h4A;
    localparam logic [7:0] OFF_XCTL_B   = 8'h4B;
    localparam logic [7:0] OFF_XPTR_LO  = 8'h50;
    localparam logic [7:0] OFF_XPTR_HI  = 8'h51;
    localparam logic [7:0] OFF_XDATA    = 8'h53;

    localparam int LO_RAM_BYTES = 50;
    localparam int HI_RAM_BYTES = 64;
    localparam int BANK_BIT     = 4;
    localparam int BURST_BIT    = 5;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRLA,
        RG_CTRLB,
        RG_CTRLC,
        RG_CTRLD,
        RG_RAM_LO,
        RG_RAM_HI,
        RG_ID,
        RG_XCTLA,
        RG_XCTLB,
        RG_XPTR_LO,
        RG_XPTR_HI,
        RG_XDATA
    } region_t;
endpackage

// File: rtl/rtc_bank_decode.sv
// Offset decoder: maps a bus offset and the bank bit onto a region and a
// RAM index. Purely combinational; assumes offsets above 0x7F are unmapped.
module rtc_bank_decode
    import rtc_bank_pkg::*;
(
    input  logic [7:0] addr,
    input  logic       bank_hi,
    output region_t    region,
    output logic [5:0] idx
);
    // Region select: fixed registers first, then scratch RAM, then the window.
    always_comb begin
        region = RG_NONE;
        if (addr == OFF_CTRL_A)      region = RG_CTRLA;
        else if (addr == OFF_CTRL_B) region = RG_CTRLB;
        else if (addr == OFF_CTRL_C) region = RG_CTRLC;
        else if (addr == OFF_CTRL_D) region = RG_CTRLD;
        else if (addr >= OFF_LO_FIRST && addr <= OFF_LO_LAST) region = RG_RAM_LO;
        else if (addr[7:6] == 2'b01) begin
            if (!bank_hi)                 region = RG_RAM_HI;
            else if (addr <= OFF_ID_LAST) region = RG_ID;
            else if (addr == OFF_XCTL_A)  region = RG_XCTLA;
            else if (addr == OFF_XCTL_B)  region = RG_XCTLB;
            else if (addr == OFF_XPTR_LO) region = RG_XPTR_LO;
            else if (addr == OFF_XPTR_HI) region = RG_XPTR_HI;
            else if (addr == OFF_XDATA)   region = RG_XDATA;
        end
    end

    // RAM index: scratch RAM is rebased to zero, the window uses low bits.
    assign idx = (region == RG_RAM_LO) ? (addr[5:0] - 6'd14) : addr[5:0];

    // Window view must follow the bank bit (R2).
    always_comb begin
        p_window_bank_r2: assert (!(addr[7:6] == 2'b01 &&
                                    (bank_hi ? (region == RG_RAM_HI) : (region != RG_RAM_HI))));
    end
endmodule

// File: rtl/rtc_bank_sram.sv
// Small byte RAM with a synchronous write and a combinational read.
// Contents are not reset; IW must cover DEPTH.
module rtc_bank_sram #(
    parameter int DEPTH = 64,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/rtc_bank_ctrl.sv
// Control register set: registers A and B, the masked registers C and D, and
// the two extended control registers. Decode comes from rtc_bank_decode.
module rtc_bank_ctrl
    import rtc_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  region_t    region,
    input  logic [7:0] wdata,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic [7:0] ctrl_c,
    output logic [7:0] ctrl_d,
    output logic [7:0] xctl_a,
    output logic [7:0] xctl_b
);
    logic [3:0] c_hi;
    logic       d_top;

    // Register update on a decoded write; masked registers keep only their live bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= 8'h00;
            ctrl_b <= 8'h00;
            c_hi   <= 4'h0;
            d_top  <= 1'b0;
            xctl_a <= 8'h00;
            xctl_b <= 8'h00;
        end else if (wr) begin
            case (region)
                RG_CTRLA: ctrl_a <= wdata;
                RG_CTRLB: ctrl_b <= wdata;
                RG_CTRLC: c_hi   <= wdata[7:4];
                RG_CTRLD: d_top  <= wdata[7];
                RG_XCTLA: xctl_a <= wdata;
                RG_XCTLB: xctl_b <= wdata;
                default: ;
            endcase
        end
    end

    assign ctrl_c = {c_hi, 4'h0};
    assign ctrl_d = {d_top, 7'h00};
endmodule

// File: rtl/rtc_bank_xram.sv
// Indirect extended RAM port: 16-bit pointer, data-port read/write and burst
// stepping that wraps modulo XRAM_BYTES. Assumes XRAM_BYTES is a power of two
// no larger than 65536.
module rtc_bank_xram #(
    parameter int XRAM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_lo_wr,
    input  logic        ptr_hi_wr,
    input  logic        port_access,
    input  logic        port_wr,
    input  logic        burst_en,
    input  logic [7:0]  wdata,
    output logic [15:0] xptr,
    output logic [7:0]  port_rdata
);
    localparam int XAW = $clog2(XRAM_BYTES);

    logic [7:0]     mem [XRAM_BYTES];
    logic [XAW-1:0] cur;
    logic [XAW-1:0] step;

    assign cur  = xptr[XAW-1:0];
    assign step = cur + 1'b1;

    // Pointer: byte writes from the bus, otherwise burst stepping on an access.
    always_ff @(posedge clk) begin
        if (!rst_n)                       xptr       <= 16'h0000;
        else if (ptr_lo_wr)               xptr[7:0]  <= wdata;
        else if (ptr_hi_wr)               xptr[15:8] <= wdata;
        else if (port_access && burst_en) xptr       <= 16'(step);
    end

    // Extended RAM store through the data port.
    always_ff @(posedge clk) begin
        if (port_wr) mem[cur] <= wdata;
    end

    assign port_rdata = mem[cur];

    // Burst advances the folded pointer by one and clears the upper bits (R7).
    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_access && burst_en) |=>
            (xptr[XAW-1:0] == $past(xptr[XAW-1:0]) + 1'b1) && ((xptr >> XAW) == 16'h0));

    // Without burst the pointer stays put (R7).
    p_no_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_access && !burst_en) |=> $stable(xptr));

    // Top of RAM wraps to zero (R8).
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_access && burst_en && (&cur)) |=> (xptr == 16'h0000));

    // A data-port write reads back at an unchanged pointer (R6).
    p_port_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !burst_en) |=> (port_rdata == $past(wdata)));
endmodule

// File: rtl/rtc_bank_regs.sv
// Banked register file top: decodes the bus offset, holds the control
// registers, two scratch RAMs and the indirect extended RAM port, and
// returns combinational read data. Unmapped offsets read as zero.
module rtc_bank_regs
    import rtc_bank_pkg::*;
#(
    parameter int          XRAM_BYTES = 2048,
    parameter logic [63:0] ID_BYTES   = 64'h5A_12_34_56_78_9A_BC_71
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    region_t     region;
    logic [5:0]  idx;
    logic [7:0]  ctrl_a, ctrl_b, ctrl_c, ctrl_d, xctl_a, xctl_b;
    logic [7:0]  lo_rdata, hi_rdata, port_rdata;
    logic [15:0] xptr;
    logic        port_access;

    rtc_bank_decode u_decode (
        .addr    (bus_addr),
        .bank_hi (ctrl_a[BANK_BIT]),
        .region  (region),
        .idx     (idx)
    );

    rtc_bank_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .region (region),
        .wdata  (bus_wdata),
        .ctrl_a (ctrl_a),
        .ctrl_b (ctrl_b),
        .ctrl_c (ctrl_c),
        .ctrl_d (ctrl_d),
        .xctl_a (xctl_a),
        .xctl_b (xctl_b)
    );

    rtc_bank_sram #(.DEPTH(LO_RAM_BYTES), .IW(6)) u_lo_ram (
        .clk   (clk),
        .we    (bus_wr && region == RG_RAM_LO),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (lo_rdata)
    );

    rtc_bank_sram #(.DEPTH(HI_RAM_BYTES), .IW(6)) u_hi_ram (
        .clk   (clk),
        .we    (bus_wr && region == RG_RAM_HI),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (hi_rdata)
    );

    assign port_access = (region == RG_XDATA) && (bus_wr || bus_rd);

    rtc_bank_xram #(.XRAM_BYTES(XRAM_BYTES)) u_xram (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_lo_wr   (bus_wr && region == RG_XPTR_LO),
        .ptr_hi_wr   (bus_wr && region == RG_XPTR_HI),
        .port_access (port_access),
        .port_wr     (bus_wr && region == RG_XDATA),
        .burst_en    (xctl_a[BURST_BIT]),
        .wdata       (bus_wdata),
        .xptr        (xptr),
        .port_rdata  (port_rdata)
    );

    // Read mux: one source per region, zero for anything unmapped.
    always_comb begin
        case (region)
            RG_CTRLA:   bus_rdata = ctrl_a;
            RG_CTRLB:   bus_rdata = ctrl_b;
            RG_CTRLC:   bus_rdata = ctrl_c;
            RG_CTRLD:   bus_rdata = ctrl_d;
            RG_RAM_LO:  bus_rdata = lo_rdata;
            RG_RAM_HI:  bus_rdata = hi_rdata;
            RG_ID:      bus_rdata = ID_BYTES[{idx[2:0], 3'b000} +: 8];
            RG_XCTLA:   bus_rdata = xctl_a;
            RG_XCTLB:   bus_rdata = xctl_b;
            RG_XPTR_LO: bus_rdata = xptr[7:0];
            RG_XPTR_HI: bus_rdata = xptr[15:8];
            RG_XDATA:   bus_rdata = port_rdata;
            default:    bus_rdata = 8'h00;
        endcase
    end

    // Low nibble of register C never shows a one (R5).
    p_ctrl_c_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_CTRLC) |-> (bus_rdata[3:0] == 4'h0));

    // Unmapped offsets return zero (R9).
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_NONE) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/rtc_bank_regs_tb.sv
// Bench: behavioural reference model (integer arrays, -1 = unknown) compared
// with the read data on every bus cycle.
module rtc_bank_regs_tb;
    localparam int          XB  = 2048;
    localparam logic [63:0] IDB = 64'h3C_A1_B2_C3_D4_E5_F6_7E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    int m_ca = 0, m_cb = 0, m_cc = 0, m_cd = 0, m_xa = 0, m_xb = 0, m_ptr = 0;
    int lo_m [50];
    int hi_m [64];
    int xm   [XB];

    always #2 clk = ~clk;

    rtc_bank_regs #(.XRAM_BYTES(XB), .ID_BYTES(IDB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic int bank();
        return (m_ca >> 4) & 1;
    endfunction

    function automatic int exp_rd(int a);
        if (a == 10) return m_ca;
        if (a == 11) return m_cb;
        if (a == 12) return m_cc;
        if (a == 13) return m_cd;
        if (a >= 14 && a <= 63) return lo_m[a-14];
        if (a >= 64 && a <= 127) begin
            if (bank() == 0) return hi_m[a-64];
            if (a <= 71) return int'(IDB[8*(a-64) +: 8]);
            if (a == 74) return m_xa;
            if (a == 75) return m_xb;
            if (a == 80) return m_ptr & 255;
            if (a == 81) return (m_ptr >> 8) & 255;
            if (a == 83) return xm[m_ptr % XB];
        end
        return 0;
    endfunction

    function automatic string req_of(int a);
        if (a == 10 || a == 11) return "R10";
        if (a == 12 || a == 13) return "R5";
        if (a >= 14 && a <= 63) return "R3";
        if (a >= 64 && a <= 127) begin
            if (bank() == 0) return "R2";
            if (a <= 71) return "R4";
            if (a == 74 || a == 75) return "R10";
            if (a == 80 || a == 81 || a == 83) return "R6";
        end
        return "R9";
    endfunction

    task automatic mdl_step(int a, bit w, bit r, int wd);
        int bk = bank();
        if (w) begin
            if (a == 10) m_ca = wd;
            else if (a == 11) m_cb = wd;
            else if (a == 12) m_cc = wd & 8'hF0;
            else if (a == 13) m_cd = wd & 8'h80;
            else if (a >= 14 && a <= 63) lo_m[a-14] = wd;
            else if (a >= 64 && a <= 127) begin
                if (bk == 0) hi_m[a-64] = wd;
                else if (a == 74) m_xa = wd;
                else if (a == 75) m_xb = wd;
                else if (a == 80) m_ptr = (m_ptr & 16'hFF00) | wd;
                else if (a == 81) m_ptr = (m_ptr & 16'h00FF) | (wd << 8);
                else if (a == 83) xm[m_ptr % XB] = wd;
            end
        end
        if (bk == 1 && a == 83 && (w || r) && ((m_xa >> 5) & 1) == 1)
            m_ptr = ((m_ptr % XB) + 1) % XB;
    endtask

    // One bus cycle: drive at negedge, compare read data, update model at posedge.
    task automatic cyc(int a, bit w, bit r, int wd, string req);
        int e;
        string tag;
        @(negedge clk);
        bus_addr  = a[7:0];
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = wd[7:0];
        #1;
        e   = exp_rd(a);
        tag = (req == "") ? req_of(a) : req;
        if (e >= 0) begin
            checks++;
            if (bus_rdata !== e[7:0]) begin
                fails++;
                $display("FAIL %s offset %02h: got %02h expected %02h", tag, a[7:0], bus_rdata, e[7:0]);
            end
        end
        @(posedge clk);
        mdl_step(a, w, r, wd);
    endtask

    task automatic wr(int a, int d, string req);
        cyc(a, 1'b1, 1'b0, d, req);
    endtask

    task automatic rd(int a, string req);
        cyc(a, 1'b0, 1'b1, 0, req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): got hang, expected completion");
        summary();
        $finish;
    end

    initial begin
        foreach (lo_m[i]) lo_m[i] = -1;
        foreach (hi_m[i]) hi_m[i] = -1;
        foreach (xm[i])   xm[i]   = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1).
        rd(8'h0A, "R1");
        rd(8'h0B, "R1");
        rd(8'h0C, "R1");
        rd(8'h0D, "R1");

        // Full-width registers and masked registers (R10, R5).
        wr(8'h0B, 8'hA5, "R10");
        rd(8'h0B, "R10");
        wr(8'h0C, 8'hFF, "R5");
        rd(8'h0C, "R5");
        wr(8'h0D, 8'hFF, "R5");
        rd(8'h0D, "R5");
        wr(8'h0D, 8'h7F, "R5");
        rd(8'h0D, "R5");

        // Scratch RAM and bank-0 window (R3, R2).
        for (int a = 14; a < 64; a++) wr(a, a ^ 8'h5A, "R3");
        for (int a = 64; a < 128; a++) wr(a, (a + 3) & 255, "R2");
        for (int a = 14; a < 64; a++) rd(a, "R3");
        for (int a = 64; a < 128; a++) rd(a, "R2");

        // Bank 1: identification bytes ignore writes (R4).
        wr(8'h0A, 8'h10, "R2");
        for (int a = 64; a < 72; a++) rd(a, "R4");
        wr(8'h41, 8'hFF, "R4");
        rd(8'h41, "R4");
        rd(8'h3F, "R3");

        // Unmapped bank-1 offsets (R9).
        wr(8'h48, 8'h11, "R9");
        rd(8'h48, "R9");
        rd(8'h52, "R9");
        wr(8'h60, 8'h22, "R9");
        rd(8'h60, "R9");
        wr(8'h4B, 8'hC3, "R10");
        rd(8'h4B, "R10");

        // Burst fill of the whole extended RAM, then wrapped pointer (R7, R8).
        wr(8'h4A, 8'h20, "R10");
        rd(8'h4A, "R10");
        wr(8'h50, 8'h00, "R6");
        wr(8'h51, 8'h00, "R6");
        for (int i = 0; i < XB; i++) wr(8'h53, (i * 7 + 1) & 255, "R7");
        rd(8'h50, "R8");
        rd(8'h51, "R8");
        for (int i = 0; i < XB; i++) rd(8'h53, "R7");
        rd(8'h50, "R8");

        // No strobe: no step even in burst mode (R7).
        wr(8'h50, 8'h10, "R6");
        cyc(8'h53, 1'b0, 1'b0, 0, "R7");
        rd(8'h50, "R7");

        // Burst off: pointer holds over reads and writes (R7, R6).
        wr(8'h4A, 8'h00, "R7");
        wr(8'h51, 8'h01, "R6");
        wr(8'h50, 8'h23, "R6");
        rd(8'h53, "R7");
        rd(8'h53, "R7");
        wr(8'h53, 8'h9C, "R6");
        rd(8'h53, "R6");
        rd(8'h50, "R7");
        rd(8'h51, "R7");

        // Pointer beyond the RAM size is folded; burst from the top wraps (R6, R8).
        wr(8'h4A, 8'h20, "R8");
        wr(8'h51, 8'hFF, "R6");
        wr(8'h50, 8'hFF, "R6");
        rd(8'h51, "R6");
        rd(8'h53, "R8");
        rd(8'h50, "R8");
        rd(8'h51, "R8");
        rd(8'h53, "R8");

        // Back to bank 0: window RAM kept its contents (R2).
        wr(8'h0A, 8'h00, "R2");
        for (int a = 64; a < 72; a++) rd(a, "R2");
        rd(8'h7F, "R2");

        // Unmapped low and high offsets (R9).
        for (int a = 0; a < 10; a++) wr(a, 8'hFF, "R9");
        for (int a = 0; a < 10; a++) rd(a, "R9");
        wr(8'h80, 8'h55, "R9");
        rd(8'h80, "R9");
        rd(8'hFF, "R9");
        rd(8'h0E, "R3");

        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        summary();
        $finish;
    end
endmodule